// File: doc/BRIEF.md
# Execute-Stage Operand Selector

This block chooses the three operands that an instruction presents to the execute stage of a five-stage pipeline. These are the two ALU inputs (A and B) and the store-data operand (D). For each operand it starts from the register-file read value. It then compares the operand's source register address against the destination of each older instruction still in flight. If there is a match, it substitutes the newest result that is still waiting to be written. The older instructions sit in three places: the instruction that has just left execute, the memory stage, and write-back.

Decode control can also replace operand A with the current program counter and operand B with the decoded immediate. These replacements override any forwarding for that operand. Operand D is never replaced, because stores need their data register at full freshness. The write-back candidate is either the ALU result or the loaded data, as the write-back control selects. The selector is purely combinational.

Top module: `exec_operand_sel`

## Requirements
- R1: When no in-flight stage writes the operand's source register, the operand equals its register-file read value.
- R2: When only the write-back stage matches (write enable 1, destination equal to the source, destination nonzero) and wb_sel_load is 0, the operand equals wb_alu_val.
- R3: When only the write-back stage matches and wb_sel_load is 1, the operand equals wb_load_val.
- R4: When the memory stage matches, the operand equals mem_val, even if write-back also matches.
- R5: When the previous-ALU stage matches, the operand equals alu_prev_val, whatever the memory and write-back stages hold.
- R6: A source address of 0 is never forwarded; the operand equals the register-file read value.
- R7: A stage whose write enable is 0 is never forwarded from, even when its destination equals the source.
- R8: With use_pc_a at 1, op_a equals pc regardless of any forwarding match.
- R9: With use_imm_b at 1, op_b equals imm regardless of any forwarding match.
- R10: op_d follows the same forwarding rules R1 to R7 using src_d and rf_d, and is unaffected by use_pc_a and use_imm_b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | AW | Source register address for operand A |
| src_b | input | AW | Source register address for operand B |
| src_d | input | AW | Source register address for store data D |
| rf_a | input | XLEN | Register-file read data for A |
| rf_b | input | XLEN | Register-file read data for B |
| rf_d | input | XLEN | Register-file read data for D |
| pc | input | XLEN | Program counter of the instruction in execute |
| imm | input | XLEN | Decoded immediate |
| use_pc_a | input | 1 | Select pc as operand A |
| use_imm_b | input | 1 | Select imm as operand B |
| alu_prev_we | input | 1 | Previous ALU result writes a register |
| alu_prev_rd | input | AW | Destination of previous ALU result |
| alu_prev_val | input | XLEN | Previous ALU result |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_rd | input | AW | Memory-stage destination |
| mem_val | input | XLEN | Memory-stage result |
| wb_we | input | 1 | Write-back instruction writes a register |
| wb_rd | input | AW | Write-back destination |
| wb_alu_val | input | XLEN | Write-back ALU result |
| wb_load_val | input | XLEN | Write-back loaded data |
| wb_sel_load | input | 1 | 1 selects loaded data for write-back |
| op_a | output | XLEN | Selected operand A |
| op_b | output | XLEN | Selected operand B |
| op_d | output | XLEN | Selected store-data operand D |

## Verification
The checks assume that every input carries a known value. They are evaluated only once no input bit is X or Z, so the time before the first drive is excluded. The checks make no assumption about how the pipeline fills, because any combination of enables and destinations is legal at this boundary.

The stimulus uses a two-bit address space. It sweeps every source address against every destination and enable setting of all three stages. The override and load-select controls are cycled alongside, so every priority pairing and the register-0 case occur many times.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int NUM_STG = 3;   // 0 = previous ALU, 1 = memory, 2 = write-back
  localparam int NUM_OPS = 3;   // 0 = A, 1 = B, 2 = D

  typedef enum logic [2:0] {
    FWD_RF  = 3'd0,
    FWD_ALU = 3'd1,
    FWD_MEM = 3'd2,
    FWD_WB  = 3'd3,
    FWD_OVR = 3'd4
  } fwd_src_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int AW = 5
) (
  input  logic          stg_we,
  input  logic [AW-1:0] stg_rd,
  input  logic [AW-1:0] src,
  output logic          hit
);
  // register 0 is hard-wired zero and never takes a forwarded value
  always_comb begin
    hit = stg_we && (stg_rd != '0) && (stg_rd == src);
  end
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
  import fwd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [NUM_STG-1:0]           hits,
  input  logic [NUM_STG-1:0][XLEN-1:0] stg_val,
  input  logic [XLEN-1:0]              rf_val,
  input  logic                         ovr_en,
  input  logic [XLEN-1:0]              ovr_val,
  output logic [XLEN-1:0]              op
);
  fwd_src_e sel;

  // youngest producer (lowest stage index) wins; decode override beats all
  always_comb begin
    if (ovr_en)        sel = FWD_OVR;
    else if (hits[0])  sel = FWD_ALU;
    else if (hits[1])  sel = FWD_MEM;
    else if (hits[2])  sel = FWD_WB;
    else               sel = FWD_RF;
  end

  always_comb begin
    unique case (sel)
      FWD_OVR: op = ovr_val;
      FWD_ALU: op = stg_val[0];
      FWD_MEM: op = stg_val[1];
      FWD_WB:  op = stg_val[2];
      default: op = rf_val;
    endcase
  end
endmodule

// File: rtl/exec_operand_sel.sv
module exec_operand_sel
  import fwd_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input  logic [AW-1:0]   src_a,
  input  logic [AW-1:0]   src_b,
  input  logic [AW-1:0]   src_d,
  input  logic [XLEN-1:0] rf_a,
  input  logic [XLEN-1:0] rf_b,
  input  logic [XLEN-1:0] rf_d,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] imm,
  input  logic            use_pc_a,
  input  logic            use_imm_b,
  input  logic            alu_prev_we,
  input  logic [AW-1:0]   alu_prev_rd,
  input  logic [XLEN-1:0] alu_prev_val,
  input  logic            mem_we,
  input  logic [AW-1:0]   mem_rd,
  input  logic [XLEN-1:0] mem_val,
  input  logic            wb_we,
  input  logic [AW-1:0]   wb_rd,
  input  logic [XLEN-1:0] wb_alu_val,
  input  logic [XLEN-1:0] wb_load_val,
  input  logic            wb_sel_load,
  output logic [XLEN-1:0] op_a,
  output logic [XLEN-1:0] op_b,
  output logic [XLEN-1:0] op_d
);
  logic [XLEN-1:0]              wb_val;
  logic [NUM_STG-1:0]           stg_we;
  logic [NUM_STG-1:0][AW-1:0]   stg_rd;
  logic [NUM_STG-1:0][XLEN-1:0] stg_val;
  logic [NUM_OPS-1:0][AW-1:0]   op_src;
  logic [NUM_OPS-1:0][XLEN-1:0] op_rf;
  logic [NUM_OPS-1:0]           op_ovr_en;
  logic [NUM_OPS-1:0][XLEN-1:0] op_ovr_val;
  logic [NUM_OPS-1:0][XLEN-1:0] op_res;

  // write-back candidate is the value actually written to the register file
  always_comb begin
    wb_val = wb_sel_load ? wb_load_val : wb_alu_val;
  end

  always_comb begin
    stg_we     = {wb_we, mem_we, alu_prev_we};
    stg_rd     = {wb_rd, mem_rd, alu_prev_rd};
    stg_val    = {wb_val, mem_val, alu_prev_val};
    op_src     = {src_d, src_b, src_a};
    op_rf      = {rf_d, rf_b, rf_a};
    op_ovr_en  = {1'b0, use_imm_b, use_pc_a};
    op_ovr_val = {{XLEN{1'b0}}, imm, pc};
  end

  for (genvar o = 0; o < NUM_OPS; o++) begin : g_op
    logic [NUM_STG-1:0] hits;
    for (genvar s = 0; s < NUM_STG; s++) begin : g_stg
      fwd_match #(.AW(AW)) u_match (
        .stg_we (stg_we[s]),
        .stg_rd (stg_rd[s]),
        .src    (op_src[o]),
        .hit    (hits[s])
      );
    end
    fwd_pick #(.XLEN(XLEN)) u_pick (
      .hits    (hits),
      .stg_val (stg_val),
      .rf_val  (op_rf[o]),
      .ovr_en  (op_ovr_en[o]),
      .ovr_val (op_ovr_val[o]),
      .op      (op_res[o])
    );
  end

  always_comb begin
    op_a = op_res[0];
    op_b = op_res[1];
    op_d = op_res[2];
  end
endmodule

// File: rtl/exec_operand_sel_chk.sv
module exec_operand_sel_chk #(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input logic [AW-1:0]   src_a,
  input logic [AW-1:0]   src_b,
  input logic [AW-1:0]   src_d,
  input logic [XLEN-1:0] rf_a,
  input logic [XLEN-1:0] rf_b,
  input logic [XLEN-1:0] rf_d,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] imm,
  input logic            use_pc_a,
  input logic            use_imm_b,
  input logic            alu_prev_we,
  input logic [AW-1:0]   alu_prev_rd,
  input logic [XLEN-1:0] alu_prev_val,
  input logic            mem_we,
  input logic [AW-1:0]   mem_rd,
  input logic [XLEN-1:0] mem_val,
  input logic            wb_we,
  input logic [AW-1:0]   wb_rd,
  input logic [XLEN-1:0] wb_alu_val,
  input logic [XLEN-1:0] wb_load_val,
  input logic            wb_sel_load,
  input logic [XLEN-1:0] op_a,
  input logic [XLEN-1:0] op_b,
  input logic [XLEN-1:0] op_d
);
  logic known;
  logic d_alu, d_mem, d_wb;

  always_comb begin
    known = !$isunknown({src_a, src_b, src_d, rf_a, rf_b, rf_d, pc, imm,
                         use_pc_a, use_imm_b, alu_prev_we, alu_prev_rd,
                         alu_prev_val, mem_we, mem_rd, mem_val, wb_we, wb_rd,
                         wb_alu_val, wb_load_val, wb_sel_load, op_a, op_b, op_d});
    d_alu = alu_prev_we && (alu_prev_rd == src_d) && (src_d != '0);
    d_mem = mem_we && (mem_rd == src_d) && (src_d != '0);
    d_wb  = wb_we && (wb_rd == src_d) && (src_d != '0);
  end

  always_comb begin
    if (known) begin
      p_pc_override_r8: assert (!use_pc_a || op_a == pc);
      p_imm_override_r9: assert (!use_imm_b || op_b == imm);
      p_alu_youngest_r5: assert (!d_alu || op_d == alu_prev_val);
      p_mem_over_wb_r4: assert (!(d_mem && !d_alu) || op_d == mem_val);
      p_wb_load_r3: assert (!(d_wb && !d_mem && !d_alu && wb_sel_load) || op_d == wb_load_val);
      p_no_match_r1: assert ((d_alu || d_mem || d_wb) || op_d == rf_d);
      p_reg_zero_r6: assert (!(src_a == '0 && !use_pc_a) || op_a == rf_a);
    end
  end
endmodule

bind exec_operand_sel exec_operand_sel_chk #(.XLEN(XLEN), .AW(AW)) u_chk (.*);

// File: tb/tb_exec_operand_sel.sv
module tb_exec_operand_sel;
  localparam int XLEN   = 32;
  localparam int AW     = 2;
  localparam int PERIOD = 10;

  logic clk;
  logic [AW-1:0]   src_a, src_b, src_d;
  logic [XLEN-1:0] rf_a, rf_b, rf_d, pc, imm;
  logic            use_pc_a, use_imm_b;
  logic            alu_prev_we, mem_we, wb_we, wb_sel_load;
  logic [AW-1:0]   alu_prev_rd, mem_rd, wb_rd;
  logic [XLEN-1:0] alu_prev_val, mem_val, wb_alu_val, wb_load_val;
  logic [XLEN-1:0] op_a, op_b, op_d;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  exec_operand_sel #(.XLEN(XLEN), .AW(AW)) dut (.*);

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  // register-file model: register 0 reads zero, others a distinct pattern
  function automatic logic [XLEN-1:0] rf_model(input logic [AW-1:0] a);
    return (a == '0) ? '0 : (32'h0101_0000 * a + 32'h55);
  endfunction

  function automatic logic [XLEN-1:0] expect_op(input int lane,
      input logic [AW-1:0] s, output string tag);
    logic [XLEN-1:0] v;
    logic ha, hm, hw;
    ha = alu_prev_we && alu_prev_rd == s && s != 0;
    hm = mem_we && mem_rd == s && s != 0;
    hw = wb_we && wb_rd == s && s != 0;
    if (lane == 0 && use_pc_a) begin tag = "R8"; return pc; end
    if (lane == 1 && use_imm_b) begin tag = "R9"; return imm; end
    if (ha)      begin tag = "R5"; v = alu_prev_val; end
    else if (hm) begin tag = "R4"; v = mem_val; end
    else if (hw) begin tag = wb_sel_load ? "R3" : "R2";
                       v = wb_sel_load ? wb_load_val : wb_alu_val; end
    else if (s == 0) begin tag = "R6"; v = rf_model(s); end
    else if (alu_prev_rd == s || mem_rd == s || wb_rd == s)
                 begin tag = "R7"; v = rf_model(s); end
    else         begin tag = "R1"; v = rf_model(s); end
    if (lane == 2) tag = {"R10/", tag};
    return v;
  endfunction

  task automatic check_all();
    string t;
    logic [XLEN-1:0] e;
    e = expect_op(0, src_a, t); vectors++;
    if (op_a !== e) begin fails++; $display("FAIL %s op_a got %h exp %h", t, op_a, e); end
    e = expect_op(1, src_b, t); vectors++;
    if (op_b !== e) begin fails++; $display("FAIL %s op_b got %h exp %h", t, op_b, e); end
    e = expect_op(2, src_d, t); vectors++;
    if (op_d !== e) begin fails++; $display("FAIL %s op_d got %h exp %h", t, op_d, e); end
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    pc = 32'hC0DE_0400; imm = 32'h0000_7FF1;
    alu_prev_val = 32'hAAAA_0001; mem_val = 32'hBBBB_0002;
    wb_alu_val = 32'hCCCC_0003; wb_load_val = 32'hDDDD_0004;
    use_pc_a = 0; use_imm_b = 0; wb_sel_load = 0;
    alu_prev_we = 0; mem_we = 0; wb_we = 0;
    alu_prev_rd = 0; mem_rd = 0; wb_rd = 0;
    src_a = 1; src_b = 2; src_d = 3;
    rf_a = rf_model(src_a); rf_b = rf_model(src_b); rf_d = rf_model(src_d);
    @(negedge clk);
    check_all();  // R1 quiet pipeline
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < 8; a++)
        for (int m = 0; m < 8; m++)
          for (int w = 0; w < 8; w++) begin
            @(posedge clk);
            src_a = AW'(s); src_b = AW'(s + 1); src_d = AW'(s + 2);
            rf_a = rf_model(src_a); rf_b = rf_model(src_b); rf_d = rf_model(src_d);
            alu_prev_we = a[2]; alu_prev_rd = AW'(a);
            mem_we = m[2];      mem_rd = AW'(m);
            wb_we = w[2];       wb_rd = AW'(w);
            wb_sel_load = (a + m + w) % 2 == 1;
            use_pc_a  = (a + w) % 3 == 0;
            use_imm_b = (m + w) % 3 == 1;
            alu_prev_val = 32'hAAAA_0000 + 32'(a * 64 + m * 8 + w);
            mem_val = 32'hBBBB_0000 + 32'(w * 64 + a * 8 + m);
            @(negedge clk);
            check_all();
          end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule